// File: doc/BRIEF.md
# Seven-to-One Pixel Word Serializer

This block takes one 21-bit pixel word per pixel period and sends it out on three serial data lanes, seven bits per lane per period. A fourth lane carries a fixed framing pattern aligned to the same seven bit slots, so a receiver can recover both the bit rate and the word boundaries. The word holds 18 colour bits, a line sync, a frame sync and a data-enable flag. The analog line drivers and the clock multiplier sit outside the block: the bit clock, at seven times the pixel rate, is supplied directly.

The pixel clock is sampled as a level in the bit clock domain. It must keep a fixed phase to the bit clock, and each of its periods spans exactly seven bit clocks. A strobe-select input chooses which pixel clock edge captures the word. The pad is expected to carry a pull-down, so an unconnected select means falling-edge capture. An active-low power-down input clears all lanes and drops every lane's output enable. Once it is released, word framing restarts at the next active pixel clock edge.

Top module: `pix_serializer_7to1`

## Requirements
- R1: With `strobe_rise_i` high, the word is captured at the bit clock edge where a low-to-high pixel clock transition is seen. With it low, capture happens on a high-to-low transition. The other transition has no effect on capture or on slot alignment.
- R2: Lane 0 carries word bits 0..6, lane 1 carries bits 7..13 and lane 2 carries bits 14..20, each starting with the lowest bit in slot 0. In the word, bits 0..5 are red, 6..11 green, 12..17 blue, 18 line sync, 19 frame sync and 20 data enable.
- R3: A word captured at bit clock edge E shows its slot 0 bit after the next active capture edge, which is E+7 in steady state. Slot p appears after edge E+7+p.
- R4: Once framing has started, the clock lane sends 1,1,0,0,0,1,1 in slots 0..6 of each period. This gives four slots high and three slots low.
- R5: While `pd_ni` is low, after one bit clock edge all four output enables are 0 and all serial outputs are 0. Pixel clock edges are ignored during this time.
- R6: After `pd_ni` rises, all outputs stay 0 until the first active pixel edge. The period that follows that edge sends an all-zero word with the normal clock pattern, and the next period sends the first word captured after release.
- R7: While `rst_ni` is low, all serial outputs and output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_clk_i | input | 1 | Pixel clock, phase-locked to clk_i |
| pix_data_i | input | 21 | Pixel word: colour, syncs, data enable |
| strobe_rise_i | input | 1 | 1 = rising-edge capture, 0 = falling-edge capture |
| pd_ni | input | 1 | Active-low power-down |
| ser_data_o | output | 3 | Serial data, one bit per lane |
| ser_clk_o | output | 1 | Serial framing clock lane |
| lane_oe_o | output | 4 | Output enable per lane (data lanes 0..2, clock lane 3) |

## Verification
Capture happens at the bit clock edge that first sees the active pixel clock level change. Slot p of that word is due one bit clock edge after the next capture edge plus p edges. The clock lane follows the same slot timing. Output enables and the lane clear are due one bit clock edge after `pd_ni` changes. The bench drives inputs on falling bit clock edges, one phase of a seven-phase pixel waveform per bit clock. It samples 1 ns after each rising edge and compares every slot against the word it sent one pixel period earlier. This ties every check to the exact bit clock edge on which the result is due.

// File: rtl/pser_pkg.sv
package pser_pkg;
  localparam int unsigned LANES  = 3;
  localparam int unsigned SLOTS  = 7;
  localparam int unsigned WORD_W = LANES * SLOTS;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  // slot 0 is bit 0: four slots high around the boundary, three low mid-period
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/pser_capture.sv
module pser_capture #(
  parameter int unsigned W = pser_pkg::WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pix_clk_i,
  input  logic         rise_sel_i,
  input  logic         active_i,
  input  logic [W-1:0] data_i,
  output logic         load_o,
  output logic [W-1:0] shadow_o
);
  logic pix_q;
  logic edge_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= 1'b0;
    else         pix_q <= pix_clk_i;
  end

  assign edge_seen = rise_sel_i ? (pix_clk_i & ~pix_q) : (~pix_clk_i & pix_q);
  assign load_o    = edge_seen & active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shadow_o <= '0;
    else if (!active_i) shadow_o <= '0;
    else if (load_o)    shadow_o <= data_i;
  end

  assert_capture_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (pix_clk_i == rise_sel_i && pix_q != rise_sel_i));
  assert_capture_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> shadow_o == $past(data_i));
endmodule

// File: rtl/pser_lane.sv
module pser_lane #(
  parameter int unsigned SLOTS = pser_pkg::SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (flush_i) sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else              sh_q <= {1'b0, sh_q[SLOTS-1:1]};
  end

  assign ser_o = sh_q[0];

  assert_lane_first_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_i) |=> ser_o == $past(par_i[0]));
  assert_lane_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !ser_o);
endmodule

// File: rtl/pser_framer.sv
module pser_framer #(
  parameter int unsigned       SLOTS   = pser_pkg::SLOTS,
  parameter logic [SLOTS-1:0]  PATTERN = pser_pkg::CLK_PATTERN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic load_i,
  output logic clk_lane_o
);
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      run_q  <= 1'b0;
    end else if (flush_i) begin
      slot_q <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      slot_q <= '0;
      run_q  <= 1'b1;
    end else if (slot_q != LAST) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign clk_lane_o = run_q & PATTERN[slot_q];

  assert_slot_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST);
  assert_frame_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_i) |=> (slot_q == '0 && clk_lane_o == PATTERN[0]));
endmodule

// File: rtl/pix_serializer_7to1.sv
module pix_serializer_7to1 #(
  parameter int unsigned LANES = pser_pkg::LANES,
  parameter int unsigned SLOTS = pser_pkg::SLOTS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_clk_i,
  input  logic [LANES*SLOTS-1:0] pix_data_i,
  input  logic                   strobe_rise_i,
  input  logic                   pd_ni,
  output logic [LANES-1:0]       ser_data_o,
  output logic                   ser_clk_o,
  output logic [LANES:0]         lane_oe_o
);
  localparam int unsigned W = LANES * SLOTS;

  logic         load;
  logic [W-1:0] shadow;
  logic         oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= pd_ni;
  end

  assign lane_oe_o = {(LANES+1){oe_q}};

  pser_capture #(.W(W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_clk_i  (pix_clk_i),
    .rise_sel_i (strobe_rise_i),
    .active_i   (pd_ni),
    .data_i     (pix_data_i),
    .load_o     (load),
    .shadow_o   (shadow)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pser_lane #(.SLOTS(SLOTS)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (!pd_ni),
      .load_i  (load),
      .par_i   (shadow[l*SLOTS +: SLOTS]),
      .ser_o   (ser_data_o[l])
    );
  end

  pser_framer #(.SLOTS(SLOTS)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (!pd_ni),
    .load_i     (load),
    .clk_lane_o (ser_clk_o)
  );

  assert_pd_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> (lane_oe_o == '0 && ser_data_o == '0 && !ser_clk_o));
  assert_wake_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_ni) |-> (ser_data_o == '0 && !ser_clk_o));
  assert_oe_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_ni |=> lane_oe_o == '1);
endmodule

// File: tb/sim_pix_serializer_7to1.sv
`timescale 1ns/1ps
module sim_pix_serializer_7to1;
  logic        clk = 1'b0, rst_n = 1'b0, pix = 1'b0, strobe_rise = 1'b1, pd_n = 1'b1;
  logic [20:0] data = '0;
  logic [2:0]  ser_data;
  logic        ser_clk;
  logic [3:0]  oe;
  int checks = 0, fails = 0;
  localparam logic [6:0] PAT = 7'b1100011;

  always #2.5 clk = ~clk;

  pix_serializer_7to1 u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_clk_i(pix), .pix_data_i(data),
    .strobe_rise_i(strobe_rise), .pd_ni(pd_n),
    .ser_data_o(ser_data), .ser_clk_o(ser_clk), .lane_oe_o(oe));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] slot_bits(logic [20:0] w, int p);
    return {w[14+p], w[7+p], w[p]};
  endfunction

  function automatic logic pix_level(int p);
    return strobe_rise ? (p < 4) : (p >= 3);
  endfunction

  // one pixel period; lanes must carry prev (R2 lane map, R3 latency, R4 clock lane)
  task automatic run_pixel(logic [20:0] w, logic [20:0] prev, string tag);
    for (int p = 0; p < 7; p++) begin
      @(negedge clk);
      pix = pix_level(p);
      if (p == 0) data = w;
      @(posedge clk); #1;
      chk({tag, " R2 R3 data"}, 32'(ser_data), 32'(slot_bits(prev, p)));
      chk("R4 clock lane", 32'(ser_clk), 32'(PAT[p]));
      chk("R5 oe", 32'(oe), 32'hf);
    end
  endtask

  task automatic idle_pix();
    @(negedge clk); pix = pix_level(6);
    repeat (2) @(posedge clk);
  endtask

  task automatic pd_cycle(logic new_rise);
    @(negedge clk); pd_n = 1'b0;
    @(posedge clk); #1;
    chk("R5 oe off", 32'(oe), 32'h0);
    chk("R5 lanes off", 32'({ser_data, ser_clk}), 32'h0);
    for (int p = 0; p < 14; p++) begin
      @(negedge clk); pix = pix_level(p % 7); data = 21'h1ABCDE;
      @(posedge clk); #1;
      chk("R5 edges ignored", 32'({oe, ser_data, ser_clk}), 32'h0);
    end
    strobe_rise = new_rise;
    idle_pix();
    @(negedge clk); pd_n = 1'b1;
    @(posedge clk); #1;
    chk("R6 quiet after release", 32'({ser_data, ser_clk}), 32'h0);
    chk("R6 oe on", 32'(oe), 32'hf);
  endtask

  task automatic stream(int n_rand);
    logic [20:0] prev;
    logic [20:0] w;
    logic [20:0] dir [5];
    dir[0] = 21'h1FFFFF; dir[1] = 21'h000001; dir[2] = 21'h100000;
    dir[3] = 21'h0AAAAA; dir[4] = 21'h040080;
    prev = '0;  // R6: first period after start sends zeros
    for (int i = 0; i < 5 + n_rand; i++) begin
      w = (i < 5) ? dir[i] : 21'($urandom());
      run_pixel(w, prev, (i == 0) ? "R6 R1" : "R1");
      prev = w;
    end
    run_pixel(21'h0, prev, "R1 tail");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset lanes", 32'({ser_data, ser_clk}), 32'h0);
    chk("R7 reset oe", 32'(oe), 32'h0);
    idle_pix();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 oe after reset", 32'(oe), 32'hf);
    stream(25);           // rising capture
    pd_cycle(1'b0);
    stream(25);           // falling capture
    pd_cycle(1'b1);
    stream(10);           // back to rising
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule